// File: doc/BRIEF.md
# Isolated I/O Register Bank with Change-of-State Interrupt

This block gives a host a byte-wide register window onto sixteen latched output drivers and sixteen isolated digital inputs. The host bus has a 3-bit address, single-cycle read and write strobes, an 8-bit write bus and an 8-bit read bus. Read data is a combinational function of the address and the current state. Any side effect of an access takes effect on the clock edge where its strobe is high.

Several registers act on the kind of access and ignore the data. A read of the interrupt-control offset turns interrupt generation on, and any write to it turns generation off. A read of the filter-control offset switches the input filters on, and any write switches them off. Any write to the low-input offset clears the pending change flags. Every input goes through a two-flop synchroniser. An optional stability filter can follow it. A change of the accepted level in either direction is recorded per input byte, and the single level interrupt output is driven while interrupts are enabled and a change is pending.

Top module: `iso_io_bank`

## Requirements
- R1: A write to offset 0 loads `dout[7:0]`, and a write to offset 4 loads `dout[15:8]`, on the strobed edge. A read of either offset returns the byte last written. No other access changes `dout`.
- R2: A read of offset 1 returns the accepted levels of inputs 0 to 7, with bit i holding input i. A read of offset 5 returns inputs 8 to 15 in the same way.
- R3: A read of offset 2 enables the interrupt, and any write to offset 2 disables it. A write wins if both strobes are high together. Disabling does not clear the pending flags.
- R4: Any write to offset 1 clears both pending flags, whatever the data. A change accepted on the same edge still sets its flag.
- R5: A rising or a falling change of any accepted input level sets status bit 0 for inputs 0 to 7 or status bit 1 for inputs 8 to 15. This happens even while the interrupt is disabled.
- R6: A read of offset 6 returns status. Bit 0 is the low-byte flag, bit 1 is the high-byte flag, bit 2 is enable AND (bit 0 OR bit 1), and bits 7 to 3 are zero. `irq` equals status bit 2.
- R7: A read of offset 3 turns the filters on, and any write to offset 3 turns them off. With the filters off, a one-cycle pin pulse is accepted and recorded.
- R8: With the filters on, a new level is accepted only after the synchronised input differs from the accepted level for FILT_CYC consecutive cycles. A pin change shows at the register FILT_CYC+2 edges after it is driven. Shorter pulses change nothing.
- R9: With the filters off, a pin change shows in the input register and in the status register 3 edges after it is driven.
- R10: Writes to offsets 5, 6 and 7 have no effect. Reads of offsets 0, 1, 4, 5 and 6 have no side effect. Reads of offsets 2, 3 and 7 return zero.
- R11: Reset clears the outputs, disables the interrupt, clears both pending flags and leaves the filters off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| din | input | 16 | Raw isolated input pins |
| dout | output | 16 | Output driver latches |
| irq | output | 1 | Level interrupt |

## Verification
The clear write to offset 1 and a newly accepted input change can land on the same clock edge. The bench provokes this by setting a pending low-byte flag first. It then drives a high-byte pin change and times the clear-write strobe to hit the third edge after the pin change, which is the edge where that change is accepted. The status read that follows must show the high-byte flag set and the low-byte flag cleared. This shows that the new change survives the clear and that the clear still removes the older flag.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;

    typedef enum logic [2:0] {
        OFS_OUT_LO  = 3'd0,
        OFS_IN_LO   = 3'd1,
        OFS_IRQ_CTL = 3'd2,
        OFS_FLT_CTL = 3'd3,
        OFS_OUT_HI  = 3'd4,
        OFS_IN_HI   = 3'd5,
        OFS_STAT    = 3'd6,
        OFS_SPARE   = 3'd7
    } ofs_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       own;
        logic       hi_chg;
        logic       lo_chg;
    } stat_t;

    typedef struct packed {
        logic out_lo_wr;
        logic out_hi_wr;
        logic clr_wr;
        logic irq_on;
        logic irq_off;
        logic flt_on;
        logic flt_off;
    } acc_t;

    function automatic acc_t decode_acc(logic [2:0] a, logic rd, logic wr);
        acc_t r;
        r = '0;
        unique case (ofs_e'(a))
            OFS_OUT_LO:  r.out_lo_wr = wr;
            OFS_OUT_HI:  r.out_hi_wr = wr;
            OFS_IN_LO:   r.clr_wr    = wr;
            OFS_IRQ_CTL: begin
                r.irq_off = wr;
                r.irq_on  = rd & ~wr;
            end
            OFS_FLT_CTL: begin
                r.flt_off = wr;
                r.flt_on  = rd & ~wr;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic stat_t pack_stat(logic en, logic lo, logic hi);
        stat_t s;
        s.rsvd   = '0;
        s.own    = en & (lo | hi);
        s.hi_chg = hi;
        s.lo_chg = lo;
        return s;
    endfunction

endpackage

// File: rtl/iso_in_cond.sv
module iso_in_cond #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flt_en,
    input  logic pin,
    output logic lvl,
    output logic chg
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    logic          s1, s2;
    logic [CW-1:0] cnt, cnt_nx;
    logic          lvl_nx;

    always_comb begin
        lvl_nx = lvl;
        cnt_nx = '0;
        if (!flt_en) begin
            lvl_nx = s2;
        end else if (s2 != lvl) begin
            if (cnt == CNT_LAST) lvl_nx = s2;
            else                 cnt_nx = cnt + 1'b1;
        end
    end

    assign chg = lvl_nx ^ lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            lvl <= 1'b0;
            cnt <= '0;
        end else begin
            s1  <= pin;
            s2  <= s1;
            lvl <= lvl_nx;
            cnt <= cnt_nx;
        end
    end
endmodule

// File: rtl/iso_chg_irq.sv
module iso_chg_irq (
    input  logic clk,
    input  logic rst,
    input  logic chg_lo,
    input  logic chg_hi,
    input  logic clr,
    input  logic en_set,
    input  logic en_clr,
    output logic lo_pend,
    output logic hi_pend,
    output logic irq_en,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_pend <= 1'b0;
            hi_pend <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            if (chg_lo)   lo_pend <= 1'b1;
            else if (clr) lo_pend <= 1'b0;
            if (chg_hi)   hi_pend <= 1'b1;
            else if (clr) hi_pend <= 1'b0;
            if (en_clr)      irq_en <= 1'b0;
            else if (en_set) irq_en <= 1'b1;
        end
    end

    assign irq = irq_en & (lo_pend | hi_pend);
endmodule

// File: rtl/iso_io_bank.sv
module iso_io_bank
    import iso_io_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int FILT_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            addr,
    input  logic                  rd_stb,
    input  logic                  wr_stb,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [2*BYTE_W-1:0]   din,
    output logic [2*BYTE_W-1:0]   dout,
    output logic                  irq
);
    localparam int NPIN = 2 * BYTE_W;

    acc_t             acc;
    logic [BYTE_W-1:0] out_lo, out_hi;
    logic             flt_en;
    logic [NPIN-1:0]  lvl, chg;
    logic             chg_lo, chg_hi;
    logic             lo_pend, hi_pend, irq_en;
    stat_t            stat;

    assign acc = decode_acc(addr, rd_stb, wr_stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_lo <= '0;
            out_hi <= '0;
            flt_en <= 1'b0;
        end else begin
            if (acc.out_lo_wr) out_lo <= wdata;
            if (acc.out_hi_wr) out_hi <= wdata;
            if (acc.flt_off)     flt_en <= 1'b0;
            else if (acc.flt_on) flt_en <= 1'b1;
        end
    end

    assign dout = {out_hi, out_lo};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        iso_in_cond #(.FILT_CYC(FILT_CYC)) u_cond (
            .clk    (clk),
            .rst    (rst),
            .flt_en (flt_en),
            .pin    (din[i]),
            .lvl    (lvl[i]),
            .chg    (chg[i])
        );
    end

    assign chg_lo = |chg[BYTE_W-1:0];
    assign chg_hi = |chg[NPIN-1:BYTE_W];

    iso_chg_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .chg_lo  (chg_lo),
        .chg_hi  (chg_hi),
        .clr     (acc.clr_wr),
        .en_set  (acc.irq_on),
        .en_clr  (acc.irq_off),
        .lo_pend (lo_pend),
        .hi_pend (hi_pend),
        .irq_en  (irq_en),
        .irq     (irq)
    );

    assign stat = pack_stat(irq_en, lo_pend, hi_pend);

    always_comb begin
        unique case (ofs_e'(addr))
            OFS_OUT_LO: rdata = out_lo;
            OFS_OUT_HI: rdata = out_hi;
            OFS_IN_LO:  rdata = lvl[BYTE_W-1:0];
            OFS_IN_HI:  rdata = lvl[NPIN-1:BYTE_W];
            OFS_STAT:   rdata = BYTE_W'(stat);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/iso_io_bank_chk.sv
module iso_io_bank_chk #(
    parameter int NPIN = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      addr,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic [NPIN-1:0] dout,
    input logic            irq_en,
    input logic            lo_pend,
    input logic            hi_pend,
    input logic            chg_lo,
    input logic            chg_hi
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && (addr == 3'd0 || addr == 3'd4)) |=> $stable(dout)); // R1

    AST_IRQ_OFF_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && addr == 3'd2) |=> !irq_en); // R3

    AST_IRQ_ON_RD: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !wr_stb && addr == 3'd2) |=> irq_en); // R3

    AST_CLR_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && addr == 3'd1 && !chg_lo && !chg_hi) |=> (!lo_pend && !hi_pend)); // R4

    AST_CHG_SETS: assert property (@(posedge clk) disable iff (rst)
        (chg_lo || chg_hi) |=> ((lo_pend || !$past(chg_lo)) && (hi_pend || !$past(chg_hi)))); // R5

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (dout == '0 && !irq_en && !lo_pend && !hi_pend)); // R11
endmodule

bind iso_io_bank iso_io_bank_chk #(.NPIN(2 * BYTE_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .dout    (dout),
    .irq_en  (irq_en),
    .lo_pend (lo_pend),
    .hi_pend (hi_pend),
    .chg_lo  (chg_lo),
    .chg_hi  (chg_hi)
);

// File: tb/test_iso_io_bank.sv
module test_iso_io_bank;
    localparam int FILT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        irq;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iso_io_bank #(.BYTE_W(8), .FILT_CYC(FILT)) i_iso_io_bank (
        .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wdata(wdata), .rdata(rdata), .din(din), .dout(dout), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] a;
        logic [7:0] d;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 8'hA5, 8'h00, 4'd1},
        '{1'b0, 3'd0, 8'h00, 8'hA5, 4'd1},
        '{1'b1, 3'd4, 8'h3C, 8'h00, 4'd1},
        '{1'b0, 3'd4, 8'h00, 8'h3C, 4'd1},
        '{1'b0, 3'd0, 8'h00, 8'hA5, 4'd1},
        '{1'b1, 3'd5, 8'hFF, 8'h00, 4'd10},
        '{1'b1, 3'd6, 8'hFF, 8'h00, 4'd10},
        '{1'b1, 3'd7, 8'hFF, 8'h00, 4'd10},
        '{1'b0, 3'd4, 8'h00, 8'h3C, 4'd10},
        '{1'b0, 3'd1, 8'h00, 8'h00, 4'd10},
        '{1'b0, 3'd5, 8'h00, 8'h00, 4'd10},
        '{1'b0, 3'd6, 8'h00, 8'h00, 4'd10},
        '{1'b0, 3'd7, 8'h00, 8'h00, 4'd10},
        '{1'b0, 3'd2, 8'h00, 8'h00, 4'd10},
        '{1'b0, 3'd3, 8'h00, 8'h00, 4'd10},
        '{1'b1, 3'd3, 8'h00, 8'h00, 4'd7},
        '{1'b1, 3'd2, 8'h00, 8'h00, 4'd3},
        '{1'b1, 3'd0, 8'h5A, 8'h00, 4'd1},
        '{1'b0, 3'd0, 8'h00, 8'h5A, 4'd1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        rd_stb = 1'b1;
        #5;
        chk(tag, {8'h00, rdata}, {8'h00, exp});
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a;
        wdata = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        ticks(1);

        // R11 reset state
        chk("R11 dout after reset", dout, 16'h0000);
        chk("R11 irq after reset", {15'd0, irq}, 16'h0000);
        rd_chk(3'd6, 8'h00, "R11 status after reset");

        // vector table: R1 and R10 register behaviour
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].a, VECS[i].d);
            end else begin
                rd_chk(VECS[i].a, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
            end
        end
        chk("R1 dout pins", dout, 16'h3C5A);

        // R9 latency with filters off; R5 recorded while disabled
        din = 16'h0008;
        ticks(2);
        rd_chk(3'd1, 8'h00, "R9 not yet at edge 2");
        rd_chk(3'd1, 8'h08, "R9 visible at edge 3");
        rd_chk(3'd6, 8'h01, "R5 recorded while disabled");
        chk("R6 irq low while disabled", {15'd0, irq}, 16'h0000);

        // R3 enable by read, R6 status bit 2 and irq
        rd_chk(3'd2, 8'h00, "R3 enable read");
        rd_chk(3'd6, 8'h05, "R6 status own bit");
        chk("R6 irq follows status", {15'd0, irq}, 16'h0001);

        // R2 high byte input, R6 both group bits
        din = 16'h1008;
        ticks(3);
        rd_chk(3'd5, 8'h10, "R2 high input byte");
        rd_chk(3'd6, 8'h07, "R6 both groups");

        // R4 clear regardless of data
        wr(3'd1, 8'h00);
        rd_chk(3'd6, 8'h00, "R4 clear write");
        chk("R4 irq after clear", {15'd0, irq}, 16'h0000);

        // R5 falling edge
        din = 16'h1000;
        ticks(3);
        rd_chk(3'd6, 8'h05, "R5 falling edge");

        // R3 disable keeps pending
        wr(3'd2, 8'hFF);
        rd_chk(3'd6, 8'h01, "R3 disable keeps pending");
        chk("R3 irq after disable", {15'd0, irq}, 16'h0000);

        // R4 clear coinciding with a new accepted change
        din = 16'h1200;
        ticks(2);
        wr(3'd1, 8'hC3);
        rd_chk(3'd6, 8'h02, "R4 same-edge change survives clear");
        wr(3'd1, 8'h00);
        rd_chk(3'd6, 8'h00, "R4 second clear");

        // R8 filtering
        rd_chk(3'd3, 8'h00, "R7 filter on read");
        din = 16'h1220;
        ticks(5);
        din = 16'h1200;
        ticks(FILT + 4);
        rd_chk(3'd1, 8'h00, "R8 short pulse level");
        rd_chk(3'd6, 8'h00, "R8 short pulse status");
        din = 16'h1220;
        ticks(FILT + 1);
        rd_chk(3'd1, 8'h00, "R8 not yet accepted");
        rd_chk(3'd1, 8'h20, "R8 accepted after FILT cycles");
        rd_chk(3'd6, 8'h01, "R8 status after accept");

        // R7 filters off: one-cycle pulse recorded
        wr(3'd3, 8'h55);
        wr(3'd1, 8'h00);
        din = 16'h1200;
        ticks(1);
        din = 16'h1220;
        ticks(4);
        rd_chk(3'd6, 8'h01, "R7 pulse recorded with filters off");
        rd_chk(3'd1, 8'h20, "R7 level restored");

        // R11 reset mid-run
        rd_chk(3'd2, 8'h00, "R3 enable before reset");
        rd_chk(3'd3, 8'h00, "R7 filter on before reset");
        chk("R6 irq before reset", {15'd0, irq}, 16'h0001);
        din = 16'h0000;
        ticks(4);
        rst = 1'b1;
        ticks(2);
        rst = 1'b0;
        ticks(1);
        chk("R11 dout cleared", dout, 16'h0000);
        chk("R11 irq cleared", {15'd0, irq}, 16'h0000);
        rd_chk(3'd6, 8'h00, "R11 status cleared");
        din = 16'h0001;
        ticks(1);
        din = 16'h0000;
        ticks(4);
        rd_chk(3'd6, 8'h01, "R11 filters off after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule